// File: doc/BRIEF.md
# BCD Timekeeper with Transfer Freeze

This block is a calendar clock that counts hundredths of a second, seconds, minutes, hours, day of week, date, month and two-digit year, every field in packed BCD. A host reaches it through a small register window with an address, a write strobe and a combinational read port. The oscillator is replaced by a pulse input, `osc_tick`. Every `HUND_DIV` enabled pulses make one hundredth-of-a-second step.

The time is held twice. A working copy advances on every step. A host-visible copy follows it only while the transfer-enable bit in the command register is set. While that bit is clear, the visible copy is frozen so the host can read a consistent snapshot, and the working copy keeps counting. Once transfer is enabled again, the visible hundredths follow the next step. The other visible fields catch up at the next hundredths rollover. A host write made while frozen is held in the visible copy and moves into the working copy when transfer is enabled again.

The month register also carries two active-low controls: one stops the oscillator and one enables the square-wave output.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, reads give the following values. Address 0x0 (hundredths), 0x1 (seconds), 0x2 (minutes), 0x4 (hours) and 0xA (year) read 0x00. Address 0x6 (day) and 0x8 (date) read 0x01. Address 0x9 (month) reads 0xC1. Address 0xB (command) reads 0x80. Addresses 0x3, 0x5, 0x7 and 0xC to 0xF always read 0x00.
- R2: While month bit 7 is 1 (oscillator stopped), `osc_tick` pulses do not advance any time field.
- R3: With month bit 7 at 0, each group of `HUND_DIV` `osc_tick` pulses advances hundredths by one BCD count. Hundredths wrap from 99 to 00.
- R4: A hundredths wrap carries into seconds, and a seconds wrap (59 to 00) carries into minutes. A minutes wrap (59 to 00) carries into hours. All fields count in BCD.
- R5: In 24-hour mode (hours bit 6 = 0), hours run 00 to 23 in BCD and bit 5 is the tens digit for 20 to 23. A wrap from 23 to 00 advances the date and the day. The day runs 1 to 7 and wraps to 1.
- R6: In 12-hour mode (hours bit 6 = 1), bits 4:0 count 12, 01 ... 11 in BCD and bit 5 is PM (1 = PM). Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM also advances the date and the day.
- R7: The date wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days and February has 28. February has 29 days when the BCD year is divisible by 4. The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R8: Bits with no function read 0 whatever was written. The masks are: seconds and minutes 0x7F, hours 0x7F, day 0x07, date 0x3F, month 0xDF (control bits included), command 0x80.
- R9: While command bit 7 (TE) is 0, no visible register changes unless the host writes it, and the working time keeps counting. After TE returns to 1, visible hundredths follow the next step. The other visible fields are refreshed only when hundredths wrap from 99 to 00.
- R10: A write to a time field while TE is 1 reads back at once and counts from there. A write made while TE is 0 reads back at once and is loaded into the working copy when a write of 1 to TE follows.
- R11: `sqw_oe` equals the inverse of month bit 6. `sqw_o` toggles on every `osc_tick` pulse while the oscillator runs, and holds its value while the oscillator is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| sqw_o | output | 1 | Square-wave value |
| sqw_oe | output | 1 | Output enable for the square-wave driver |

## Verification
Read data is combinational, so a read is valid in the same cycle that the address is applied. A write shows up on `rdata` one clock edge after the strobe is sampled. The `osc_tick` pulse that completes a group of `HUND_DIV` pulses changes the time at that same edge. The bench drives every strobe and pulse on the falling edge, holds it for one cycle, and samples at a later falling edge, so each result is read one full edge after it is due. Writes and ticks are never issued together, and every run keeps the number of running ticks even, so the divider phase is known at the start of each check.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W   = 4;
  localparam int NF       = 8;
  localparam int F_HUND   = 0;
  localparam int F_SEC    = 1;
  localparam int F_MIN    = 2;
  localparam int F_HOUR   = 3;
  localparam int F_DAY    = 4;
  localparam int F_DATE   = 5;
  localparam int F_MON    = 6;
  localparam int F_YEAR   = 7;
  localparam logic [ADDR_W-1:0] MON_ADDR = 4'h9;
  localparam logic [ADDR_W-1:0] CMD_ADDR = 4'hB;

  typedef logic [NF-1:0][7:0] tod_t;

  // {valid, field index} for a time-register address
  function automatic logic [3:0] field_of(logic [ADDR_W-1:0] a);
    case (a)
      4'h0: return 4'b1000;
      4'h1: return 4'b1001;
      4'h2: return 4'b1010;
      4'h4: return 4'b1011;
      4'h6: return 4'b1100;
      4'h8: return 4'b1101;
      4'h9: return 4'b1110;
      4'hA: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(logic [2:0] f);
    case (f)
      3'd1, 3'd2, 3'd3: return 8'h7F;
      3'd4:             return 8'h07;
      3'd5:             return 8'h3F;
      3'd6:             return 8'h1F;
      default:          return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] days_in_month(logic [7:0] m, logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // {day carry, next hours byte}
  function automatic logic [8:0] hour_step(logic [7:0] h);
    logic [7:0] v;
    logic pm;
    if (h[6]) begin
      pm = h[5];
      v  = {3'b000, h[4:0]};
      if (v == 8'h12) return {1'b0, 2'b01, pm, 5'h01};
      if (v == 8'h11) return {pm, 2'b01, ~pm, 5'h12};
      v = bcd_inc(v);
      return {1'b0, 2'b01, pm, v[4:0]};
    end
    if (h[5:0] == 6'h23) return {1'b1, 8'h00};
    return {1'b0, bcd_inc({2'b00, h[5:0]})};
  endfunction

  function automatic tod_t tod_advance(tod_t t);
    tod_t n;
    logic [8:0] hs;
    n = t;
    if (t[F_HUND] != 8'h99) begin
      n[F_HUND] = bcd_inc(t[F_HUND]);
      return n;
    end
    n[F_HUND] = 8'h00;
    if (t[F_SEC] != 8'h59) begin n[F_SEC] = bcd_inc(t[F_SEC]); return n; end
    n[F_SEC] = 8'h00;
    if (t[F_MIN] != 8'h59) begin n[F_MIN] = bcd_inc(t[F_MIN]); return n; end
    n[F_MIN] = 8'h00;
    hs = hour_step(t[F_HOUR]);
    n[F_HOUR] = hs[7:0];
    if (!hs[8]) return n;
    n[F_DAY] = (t[F_DAY] >= 8'h07) ? 8'h01 : t[F_DAY] + 8'd1;
    if (t[F_DATE] < days_in_month(t[F_MON], t[F_YEAR])) begin
      n[F_DATE] = bcd_inc(t[F_DATE]);
      return n;
    end
    n[F_DATE] = 8'h01;
    if (t[F_MON] < 8'h12) begin n[F_MON] = bcd_inc(t[F_MON]); return n; end
    n[F_MON]  = 8'h01;
    n[F_YEAR] = (t[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(t[F_YEAR]);
    return n;
  endfunction

  function automatic tod_t reset_tod();
    tod_t t;
    t = '0;
    t[F_DAY]  = 8'h01;
    t[F_DATE] = 8'h01;
    t[F_MON]  = 8'h01;
    return t;
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int HUND_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic step,
  output logic sq
);
  localparam int CW = (HUND_DIV > 1) ? $clog2(HUND_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HUND_DIV - 1);

  logic [CW-1:0] cnt;
  logic          live;

  assign live = run & tick;
  assign step = live & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (live) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      sq  <= ~sq;
    end
  end
endmodule

// File: rtl/rtc_tod_next.sv
module rtc_tod_next
  import rtc_pkg::*;
(
  input  tod_t cur,
  output tod_t nxt,
  output logic roll
);
  assign nxt  = tod_advance(cur);
  assign roll = (cur[F_HUND] == 8'h99);
endmodule

// File: rtl/rtc_regread.sv
module rtc_regread
  import rtc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  tod_t              vis,
  input  logic              te,
  input  logic              osc_n,
  input  logic              sqw_n,
  output logic [7:0]        rdata
);
  logic [3:0] sel;
  assign sel = field_of(addr);

  always_comb begin
    rdata = 8'h00;
    if (addr == MON_ADDR)
      rdata = {osc_n, sqw_n, 1'b0, vis[F_MON][4:0]};
    else if (addr == CMD_ADDR)
      rdata = {te, 7'b0};
    else if (sel[3])
      rdata = vis[sel[2:0]] & field_mask(sel[2:0]);
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int HUND_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sqw_o,
  output logic              sqw_oe
);
  tod_t            int_t, vis_t, nxt_t;
  logic [NF-1:0]   pend;
  logic            te, osc_n, sqw_n, run;
  logic            div_step, step_pend, step_go, roll, sq_raw;
  logic [3:0]      wsel;
  logic [2:0]      widx;
  logic            wr_time, wr_cmd, wr_mon;
  logic [7:0]      vis_hund;
  logic [8*(NF-1)-1:0] vis_upper;

  assign run = ~osc_n;

  rtc_divider #(.HUND_DIV(HUND_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(osc_tick),
    .step(div_step), .sq(sq_raw)
  );

  rtc_tod_next u_next (.cur(int_t), .nxt(nxt_t), .roll(roll));

  rtc_regread u_rd (
    .addr(addr), .vis(vis_t), .te(te), .osc_n(osc_n), .sqw_n(sqw_n),
    .rdata(rdata)
  );

  // A step meeting a host write waits one cycle.
  assign step_go   = (div_step | step_pend) & run & ~wr_en;
  assign wsel      = field_of(addr);
  assign widx      = wsel[2:0];
  assign wr_time   = wr_en & wsel[3];
  assign wr_mon    = wr_en & (addr == MON_ADDR);
  assign wr_cmd    = wr_en & (addr == CMD_ADDR);
  assign vis_hund  = vis_t[F_HUND];
  assign vis_upper = vis_t[NF-1:1];
  assign sqw_o     = sq_raw;
  assign sqw_oe    = ~sqw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_t     <= reset_tod();
      vis_t     <= reset_tod();
      pend      <= '0;
      te        <= 1'b1;
      osc_n     <= 1'b1;
      sqw_n     <= 1'b1;
      step_pend <= 1'b0;
    end else begin
      step_pend <= (div_step | step_pend) & run & wr_en;
      if (step_go) begin
        int_t <= nxt_t;
        if (te) begin
          vis_t[F_HUND] <= nxt_t[F_HUND];
          if (roll) vis_t[NF-1:1] <= nxt_t[NF-1:1];
        end
      end
      if (wr_time) begin
        vis_t[widx] <= wdata & field_mask(widx);
        if (te) int_t[widx] <= wdata & field_mask(widx);
        else    pend[widx]  <= 1'b1;
      end
      if (wr_mon) begin
        osc_n <= wdata[7];
        sqw_n <= wdata[6];
      end
      if (wr_cmd) begin
        te <= wdata[7];
        if (wdata[7] && !te) begin
          for (int i = 0; i < NF; i++)
            if (pend[i]) int_t[i] <= vis_t[i];
          pend <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        osc_n,
  input logic        te,
  input logic        step_go,
  input logic        roll,
  input logic        sqw_o,
  input logic [7:0]  vis_hund,
  input logic [55:0] vis_upper
);
  // R2
  osc_stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_n && !wr_en |=> $stable(vis_hund) && $stable(vis_upper));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !te && !wr_en |=> $stable(vis_hund) && $stable(vis_upper));

  // R9
  upper_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !(step_go && roll) |=> $stable(vis_upper));

  // R3
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_go && te && roll |=> vis_hund == 8'h00);

  // R11
  sqw_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_n |=> $stable(sqw_o));
endmodule

bind bcd_rtc bcd_rtc_chk u_chk (.*);

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sqw_o, sqw_oe;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc #(.HUND_DIV(2)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sqw_o(sqw_o), .sqw_oe(sqw_oe)
  );

  // in: hund sec min hour day date mon year | out: sec min hour day date mon year
  localparam int NV = 13;
  localparam logic [7:0] VEC [NV][15] = '{
    '{8'h99,8'h56,8'h34,8'h12,8'h03,8'h15,8'h06,8'h21, 8'h57,8'h34,8'h12,8'h03,8'h15,8'h06,8'h21},
    '{8'h99,8'h59,8'h59,8'h09,8'h02,8'h10,8'h04,8'h22, 8'h00,8'h00,8'h10,8'h02,8'h10,8'h04,8'h22},
    '{8'h99,8'h59,8'h59,8'h23,8'h07,8'h30,8'h04,8'h22, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h05,8'h22},
    '{8'h99,8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h23},
    '{8'h99,8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h24},
    '{8'h99,8'h59,8'h59,8'h23,8'h02,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h24},
    '{8'h99,8'h59,8'h59,8'h23,8'h05,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h01,8'h00},
    '{8'h99,8'h59,8'h59,8'h51,8'h03,8'h15,8'h01,8'h20, 8'h00,8'h00,8'h72,8'h03,8'h15,8'h01,8'h20},
    '{8'h99,8'h59,8'h59,8'h72,8'h03,8'h15,8'h01,8'h20, 8'h00,8'h00,8'h61,8'h03,8'h15,8'h01,8'h20},
    '{8'h99,8'h59,8'h59,8'h71,8'h04,8'h15,8'h01,8'h20, 8'h00,8'h00,8'h52,8'h05,8'h16,8'h01,8'h20},
    '{8'h99,8'h59,8'h59,8'h52,8'h05,8'h16,8'h01,8'h20, 8'h00,8'h00,8'h41,8'h05,8'h16,8'h01,8'h20},
    '{8'h99,8'h59,8'h59,8'h19,8'h06,8'h31,8'h01,8'h20, 8'h00,8'h00,8'h20,8'h06,8'h31,8'h01,8'h20},
    '{8'h99,8'h59,8'h59,8'h23,8'h06,8'h31,8'h01,8'h20, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h02,8'h20}
  };
  localparam logic [3:0] WADDR [8] = '{4'h0,4'h1,4'h2,4'h4,4'h6,4'h8,4'h9,4'hA};

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] reset_val(input logic [3:0] a);
    case (a)
      4'h6, 4'h8: return 8'h01;
      4'h9:       return 8'hC1;
      4'hB:       return 8'h80;
      default:    return 8'h00;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset map, including unused addresses
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 addr %0h", a), d, reset_val(4'(a)));
    end

    // R2 oscillator stopped: ticks do nothing
    s0 = sqw_o;
    pulse(4);
    rd(4'h0, d);
    chk("R2 hundredths while stopped", d, 8'h00);
    chk("R11 sqw held while stopped", {7'b0, sqw_o}, {7'b0, s0});

    // R11 square-wave enable and toggling
    wr(4'h9, 8'h41);
    chk("R11 oe off", {7'b0, sqw_oe}, 8'h00);
    wr(4'h9, 8'h01);
    chk("R11 oe on", {7'b0, sqw_oe}, 8'h01);
    s0 = sqw_o;
    pulse(1);
    chk("R11 toggle 1", {7'b0, sqw_o}, {7'b0, ~s0});
    pulse(1);
    chk("R11 toggle 2", {7'b0, sqw_o}, {7'b0, s0});
    wr(4'h9, 8'h41);

    // Vector table: R4 R5 R6 R7 single-step carries
    for (int v = 0; v < NV; v++) begin
      for (int f = 7; f >= 0; f--)
        wr(WADDR[f], (f == 6) ? (8'h40 | VEC[v][f]) : VEC[v][f]);
      pulse(2);
      rd(4'h0, d);
      chk($sformatf("R4 vec %0d hund", v), d, 8'h00);
      for (int f = 1; f < 8; f++) begin
        rd(WADDR[f], d);
        chk($sformatf("R4 R5 R6 R7 vec %0d field %0d", v, f), d,
            (f == 6) ? (8'h40 | VEC[v][7 + f]) : VEC[v][7 + f]);
      end
    end

    // R3 divider: one count per two ticks
    wr(4'h0, 8'h05);
    pulse(1);
    rd(4'h0, d);
    chk("R3 half group", d, 8'h05);
    pulse(1);
    rd(4'h0, d);
    chk("R3 full group", d, 8'h06);

    // R9 freeze while working copy runs
    wr(4'h0, 8'h98);
    wr(4'h1, 8'h10);
    wr(4'hB, 8'h00);
    pulse(10);
    rd(4'h0, d); chk("R9 frozen hund", d, 8'h98);
    rd(4'h1, d); chk("R9 frozen sec", d, 8'h10);
    rd(4'hB, d); chk("R9 TE reads 0", d, 8'h00);
    wr(4'hB, 8'h80);
    pulse(2);
    rd(4'h0, d); chk("R9 hund resumes", d, 8'h04);
    rd(4'h1, d); chk("R9 sec waits for wrap", d, 8'h10);
    pulse(192);
    rd(4'h0, d); chk("R9 wrap hund", d, 8'h00);
    rd(4'h1, d); chk("R9 no lost time", d, 8'h12);

    // R10 immediate write and deferred load
    wr(4'h2, 8'h45);
    rd(4'h2, d); chk("R10 immediate", d, 8'h45);
    wr(4'h0, 8'h99);
    wr(4'h1, 8'h00);
    wr(4'hB, 8'h00);
    wr(4'h2, 8'h30);
    rd(4'h2, d); chk("R10 frozen write visible", d, 8'h30);
    wr(4'hB, 8'h80);
    pulse(2);
    rd(4'h2, d); chk("R10 loaded at TE", d, 8'h30);
    rd(4'h1, d); chk("R10 sec after wrap", d, 8'h01);

    // R8 unused bits
    wr(4'h1, 8'hFF); rd(4'h1, d); chk("R8 seconds", d, 8'h7F);
    wr(4'h6, 8'hFF); rd(4'h6, d); chk("R8 day", d, 8'h07);
    wr(4'h8, 8'hFF); rd(4'h8, d); chk("R8 date", d, 8'h3F);
    wr(4'hB, 8'hFF); rd(4'hB, d); chk("R8 command", d, 8'h80);
    wr(4'h3, 8'hFF); rd(4'h3, d); chk("R8 R1 unused addr", d, 8'h00);
    wr(4'h9, 8'hFF); rd(4'h9, d); chk("R8 month", d, 8'hDF);
    chk("R11 oe off after month", {7'b0, sqw_oe}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule